// File: doc/BRIEF.md
# Dual-Port Contention Busy Arbiter

This block sits beside a two-port shared memory and decides, cycle by cycle, which port may use a location that both ports are addressing at once. Contention exists only while both port enables are active and both addresses are equal. If one port was already enabled on that address in the previous cycle, it keeps the location and the other port is told it is busy. If both arrive in the same cycle, a fairness bit picks the winner and flips after every such tie. The grant is held for as long as the match lasts.

Busy outputs are active-low. In master mode they are produced by the arbiter. In slave mode they repeat external busy inputs, so a second device can follow the master's decision when the data path is made wider. The block also gates each port's write strobe. A port that is held busy never reaches the memory write enable, including in the first cycle of a contention.

Top module: `dpa_arbiter`

## Requirements
- R1: After reset both busy outputs are high (inactive), no port owns a location, and the fairness bit selects the left port.
- R2: While the ports are not both enabled on the same address, both busy outputs stay high.
- R3: When one port was enabled on an address in the previous cycle and the other port's address moves onto it, the first port wins. The loser's busy output goes low on the clock edge that ends the first contention cycle.
- R4: When both ports arrive on a shared address in the same cycle, the first tie after reset goes to the left port. Each later tie goes to the port that lost the previous tie.
- R5: In master mode, in every cycle that follows a contention cycle, exactly one busy output is low.
- R6: The grant and its busy output hold while the match persists. Both busy outputs return high on the clock edge after the first cycle without a match.
- R7: Contention started by an enable going active, while the addresses already match, gives busy to the port that enabled later.
- R8: A port's write enable is forced low whenever that port loses arbitration, from the first cycle of contention. The winning port's write passes through.
- R9: With master_en low, the busy outputs follow busy_l_in_n and busy_r_in_n, and a low busy input blocks that port's write enable.
- R10: A write enable is high only when that port is enabled, is requesting a write and is not blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master_en | input | 1 | 1 = arbiter drives busy, 0 = busy taken from inputs |
| l_en | input | 1 | Left port enable |
| l_addr | input | ADDR_W | Left port address |
| l_wr | input | 1 | Left port write request |
| r_en | input | 1 | Right port enable |
| r_addr | input | ADDR_W | Right port address |
| r_wr | input | 1 | Right port write request |
| busy_l_in_n | input | 1 | External busy for left port, used in slave mode, active-low |
| busy_r_in_n | input | 1 | External busy for right port, used in slave mode, active-low |
| busy_l_n | output | 1 | Busy to left port, active-low |
| busy_r_n | output | 1 | Busy to right port, active-low |
| l_we | output | 1 | Gated left write enable to memory |
| r_we | output | 1 | Gated right write enable to memory |

## Verification
The assertions check four properties on every cycle. Both ports are never busy together. Exactly one port is busy after a contention cycle, and busy is released after a cycle without a match. A write enable never appears without its request, and a slave port's low busy input always blocks its write. Which port wins cannot be checked per cycle and is shown only by the bench's scenarios. Those cover address-first ordering, enable-first ordering, alternating tie results and the write blocked in the first contention cycle.

// File: rtl/dpa_pkg.sv
package dpa_pkg;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    typedef struct packed {
        owner_e owner;
        logic   tie_right;
    } grant_st_t;

    localparam int unsigned NPORT = 2;
    localparam int unsigned P_LEFT = 0;
    localparam int unsigned P_RIGHT = 1;

endpackage

// File: rtl/dpa_match.sv
module dpa_match #(
    parameter int unsigned ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_en,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              r_en,
    input  logic [ADDR_W-1:0] r_addr,
    output logic              match,
    output logic              l_held,
    output logic              r_held
);
    typedef struct packed {
        logic              l_en;
        logic [ADDR_W-1:0] l_addr;
        logic              r_en;
        logic [ADDR_W-1:0] r_addr;
    } prev_st_t;

    prev_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.l_en   = l_en;
        st_d.l_addr = l_addr;
        st_d.r_en   = r_en;
        st_d.r_addr = r_addr;
        match       = l_en && r_en && (l_addr == r_addr);
        l_held      = st_q.l_en && (st_q.l_addr == l_addr);
        r_held      = st_q.r_en && (st_q.r_addr == r_addr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/dpa_grant.sv
module dpa_grant
    import dpa_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   match,
    input  logic   l_held,
    input  logic   r_held,
    output owner_e owner_d,
    output owner_e owner_q
);
    grant_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!match) begin
            st_d.owner = OWN_NONE;
        end else if (st_q.owner == OWN_NONE) begin
            if (l_held && !r_held) begin
                st_d.owner = OWN_LEFT;
            end else if (r_held && !l_held) begin
                st_d.owner = OWN_RIGHT;
            end else begin
                st_d.owner     = st_q.tie_right ? OWN_RIGHT : OWN_LEFT;
                st_d.tie_right = !st_q.tie_right;
            end
        end
        owner_d = st_d.owner;
        owner_q = st_q.owner;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{owner: OWN_NONE, tie_right: 1'b0};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/dpa_wgate.sv
module dpa_wgate (
    input  logic en_i,
    input  logic wr_i,
    input  logic blocked_i,
    output logic we_o
);
    always_comb begin
        we_o = en_i && wr_i && !blocked_i;
    end
endmodule

// File: rtl/dpa_arbiter.sv
module dpa_arbiter
    import dpa_pkg::*;
#(
    parameter int unsigned ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_en,
    input  logic              l_en,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_wr,
    input  logic              r_en,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              r_wr,
    input  logic              busy_l_in_n,
    input  logic              busy_r_in_n,
    output logic              busy_l_n,
    output logic              busy_r_n,
    output logic              l_we,
    output logic              r_we
);
    logic   match, l_held, r_held;
    owner_e own_d, own_q;

    logic [NPORT-1:0] en_v, wr_v, blk_v, we_v, busy_int_n, busy_ext_n;

    dpa_match #(.ADDR_W(ADDR_W)) u_match (
        .clk    (clk),
        .rst_n  (rst_n),
        .l_en   (l_en),
        .l_addr (l_addr),
        .r_en   (r_en),
        .r_addr (r_addr),
        .match  (match),
        .l_held (l_held),
        .r_held (r_held)
    );

    dpa_grant u_grant (
        .clk     (clk),
        .rst_n   (rst_n),
        .match   (match),
        .l_held  (l_held),
        .r_held  (r_held),
        .owner_d (own_d),
        .owner_q (own_q)
    );

    always_comb begin
        en_v[P_LEFT]        = l_en;
        en_v[P_RIGHT]       = r_en;
        wr_v[P_LEFT]        = l_wr;
        wr_v[P_RIGHT]       = r_wr;
        busy_ext_n[P_LEFT]  = busy_l_in_n;
        busy_ext_n[P_RIGHT] = busy_r_in_n;
        busy_int_n[P_LEFT]  = (own_q != OWN_RIGHT);
        busy_int_n[P_RIGHT] = (own_q != OWN_LEFT);
        if (master_en) begin
            blk_v[P_LEFT]  = (own_d == OWN_RIGHT);
            blk_v[P_RIGHT] = (own_d == OWN_LEFT);
        end else begin
            blk_v = ~busy_ext_n;
        end
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        dpa_wgate u_wgate (
            .en_i      (en_v[p]),
            .wr_i      (wr_v[p]),
            .blocked_i (blk_v[p]),
            .we_o      (we_v[p])
        );
    end

    always_comb begin
        busy_l_n = master_en ? busy_int_n[P_LEFT]  : busy_ext_n[P_LEFT];
        busy_r_n = master_en ? busy_int_n[P_RIGHT] : busy_ext_n[P_RIGHT];
        l_we     = we_v[P_LEFT];
        r_we     = we_v[P_RIGHT];
    end
endmodule

// File: rtl/dpa_arbiter_chk.sv
module dpa_arbiter_chk #(
    parameter int unsigned ADDR_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              master_en,
    input logic              l_en,
    input logic [ADDR_W-1:0] l_addr,
    input logic              l_wr,
    input logic              r_en,
    input logic [ADDR_W-1:0] r_addr,
    input logic              r_wr,
    input logic              busy_l_in_n,
    input logic              busy_r_in_n,
    input logic              busy_l_n,
    input logic              busy_r_n,
    input logic              l_we,
    input logic              r_we
);
    logic same_loc;
    assign same_loc = l_en && r_en && (l_addr == r_addr);

    AST_NEVER_BOTH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        master_en |-> (busy_l_n || busy_r_n));  // R5

    AST_ONE_BUSY_IN_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        (master_en && $past(master_en) && $past(rst_n) && $past(same_loc))
        |-> (busy_l_n != busy_r_n));  // R5

    AST_RELEASE_AFTER_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (master_en && $past(master_en) && !$past(same_loc))
        |-> (busy_l_n && busy_r_n));  // R6

    AST_HOLD_LEFT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (master_en && $past(master_en) && $past(rst_n) && $past(same_loc) && $past(!busy_l_n))
        |-> !busy_l_n);  // R6

    AST_LEFT_WE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        l_we |-> (l_en && l_wr));  // R10

    AST_RIGHT_WE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        r_we |-> (r_en && r_wr));  // R10

    AST_SLAVE_LEFT_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_en && !busy_l_in_n) |-> !l_we);  // R9

    AST_SLAVE_RIGHT_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_en && !busy_r_in_n) |-> !r_we);  // R9
endmodule

bind dpa_arbiter dpa_arbiter_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .master_en   (master_en),
    .l_en        (l_en),
    .l_addr      (l_addr),
    .l_wr        (l_wr),
    .r_en        (r_en),
    .r_addr      (r_addr),
    .r_wr        (r_wr),
    .busy_l_in_n (busy_l_in_n),
    .busy_r_in_n (busy_r_in_n),
    .busy_l_n    (busy_l_n),
    .busy_r_n    (busy_r_n),
    .l_we        (l_we),
    .r_we        (r_we)
);

// File: tb/dpa_arbiter_test.sv
`timescale 1ns/1ps
module dpa_arbiter_test;
    localparam int unsigned AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          master_en = 1'b1;
    logic          l_en = 1'b0, r_en = 1'b0, l_wr = 1'b0, r_wr = 1'b0;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic          busy_l_in_n = 1'b1, busy_r_in_n = 1'b1;
    logic          busy_l_n, busy_r_n, l_we, r_we;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [3:0] val;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    dpa_arbiter #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .master_en(master_en),
        .l_en(l_en), .l_addr(l_addr), .l_wr(l_wr),
        .r_en(r_en), .r_addr(r_addr), .r_wr(r_wr),
        .busy_l_in_n(busy_l_in_n), .busy_r_in_n(busy_r_in_n),
        .busy_l_n(busy_l_n), .busy_r_n(busy_r_n), .l_we(l_we), .r_we(r_we)
    );

    // Driver: applies one cycle of inputs at the falling edge and queues
    // the expected {busy_l_n, busy_r_n, l_we, r_we} for that cycle.
    task automatic step(input logic ms, input logic bli, input logic bri,
                        input logic le, input logic [AW-1:0] la, input logic lw,
                        input logic re, input logic [AW-1:0] ra, input logic rw,
                        input logic [3:0] expv, input string tag);
        @(negedge clk);
        master_en = ms; busy_l_in_n = bli; busy_r_in_n = bri;
        l_en = le; l_addr = la; l_wr = lw;
        r_en = re; r_addr = ra; r_wr = rw;
        sb.push_back('{val: expv, tag: tag});
    endtask

    // Monitor: samples the outputs 2 ns after each falling edge.
    always @(negedge clk) begin
        #2;
        if (sb.size() > 0) begin
            exp_t e;
            logic [3:0] act;
            e   = sb.pop_front();
            act = {busy_l_n, busy_r_n, l_we, r_we};
            checks++;
            if (act !== e.val) begin
                fails++;
                $display("FAIL %s: {bl_n,br_n,lwe,rwe} actual=%b expected=%b", e.tag, act, e.val);
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        //          ms bli bri le la lw re ra rw  exp(bl br lwe rwe)
        step(1, 1, 1, 0, 0, 0, 0, 0, 0, 4'b1100, "R1 reset idle");
        step(1, 1, 1, 1, 3, 1, 1, 5, 1, 4'b1111, "R2 R10 different addresses");
        step(1, 1, 1, 1, 5, 1, 0, 5, 1, 4'b1110, "R2 R10 right disabled");
        step(1, 1, 1, 1, 5, 1, 1, 5, 1, 4'b1110, "R8 right blocked in first cycle");
        step(1, 1, 1, 1, 5, 1, 1, 5, 1, 4'b1010, "R3 left was first");
        step(1, 1, 1, 1, 5, 1, 1, 5, 1, 4'b1010, "R6 hold");
        step(1, 1, 1, 1, 6, 1, 1, 5, 1, 4'b1011, "R6 match ends, busy still held");
        step(1, 1, 1, 1, 6, 1, 1, 5, 1, 4'b1111, "R6 release");
        step(1, 1, 1, 1, 5, 1, 1, 5, 0, 4'b1100, "R8 left moved onto right");
        step(1, 1, 1, 1, 5, 1, 1, 5, 0, 4'b0100, "R3 right was first");
        step(1, 1, 1, 0, 5, 0, 0, 5, 0, 4'b0100, "R6 disable, busy still held");
        step(1, 1, 1, 1, 9, 1, 1, 9, 1, 4'b1110, "R4 first tie left");
        step(1, 1, 1, 1, 9, 1, 1, 9, 1, 4'b1010, "R4 R5 first tie left busy_r");
        step(1, 1, 1, 0, 9, 0, 0, 9, 0, 4'b1000, "R6 disable");
        step(1, 1, 1, 1, 2, 1, 1, 2, 1, 4'b1101, "R4 second tie right");
        step(1, 1, 1, 1, 2, 1, 1, 2, 1, 4'b0101, "R4 R5 second tie busy_l");
        step(1, 1, 1, 0, 2, 0, 0, 2, 0, 4'b0100, "R6 disable");
        step(1, 1, 1, 1, 7, 0, 0, 7, 1, 4'b1100, "R2 only left enabled");
        step(1, 1, 1, 1, 7, 0, 1, 7, 1, 4'b1100, "R7 right enables late, write blocked");
        step(1, 1, 1, 1, 7, 0, 1, 7, 1, 4'b1000, "R7 right busy");
        step(1, 1, 1, 0, 7, 0, 0, 7, 0, 4'b1000, "R6 disable");
        step(1, 1, 1, 0, 7, 0, 0, 7, 0, 4'b1100, "R6 released");
        step(0, 0, 1, 1, 4, 1, 1, 4, 1, 4'b0101, "R9 slave left busy input");
        step(0, 1, 0, 1, 4, 1, 1, 4, 1, 4'b1010, "R9 slave right busy input");
        step(0, 1, 1, 1, 4, 1, 1, 4, 1, 4'b1111, "R9 slave no busy input");
        step(0, 1, 1, 0, 4, 0, 0, 4, 0, 4'b1100, "R9 slave idle");
        step(1, 1, 1, 0, 4, 0, 0, 4, 0, 4'b1100, "R2 back to master idle");
        @(negedge clk);
        @(negedge clk);
        #5;
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule